// File: doc/BRIEF.md
# Prioritised Interrupt Target Core

This core serves one interrupt target. Software programs a priority for each source, one enable bit per source and a threshold for the target, all through a 32-bit word bus with a valid, write, address and write-data input and a same-cycle read-data return. An upstream gateway supplies the pending vector. The core picks the highest-priority source that is pending, enabled and above the threshold, latches that source's ID, and raises the interrupt output while the latched ID is nonzero.

The handler reads the claim register to get the winning ID. That read has a side effect: it sends a claim strobe with the ID to the gateway and zeroes the latched ID for one cycle, after which arbitration resumes. When the handler finishes, it writes the ID back to the same address. The core passes that value to the gateway as a completion strobe.

`NUM_SRC` sets the number of sources (1 to 180, IDs 1..NUM_SRC). ID 0 means no interrupt. Priorities are 3 bits wide and the threshold is 2 bits wide.

Top module: `plic_target`

## Requirements
- R1: The priority register for source k sits at byte address 0x030 + 4*(k-1). A write keeps bits [2:0]. A read returns the stored value zero-extended.
- R2: The threshold register at 0x318 keeps bits [1:0] of a write and reads them back. It resets to 0 and changes only when written.
- R3: Pending word w sits at 0x000 + 4*w, and bit b of that word reads source 32*w+b from `src_pend`. Bit 0 of word 0 reads 0. Writes to the pending words change nothing.
- R4: Enable word w sits at 0x300 + 4*w and stores the enable for source 32*w+b in bit b. Bit 0 of word 0 and any bit above `NUM_SRC` always read 0.
- R5: A source is a candidate when it is pending, enabled and its priority is strictly greater than the threshold. The candidate with the highest priority wins. On a tie, the lowest ID wins. With no candidate, the winner is 0.
- R6: The latched ID and `irq_o` are registered. They reflect the pending, enable, priority and threshold values of the previous cycle. `irq_o` is high exactly when the latched ID is nonzero.
- R7: A read of 0x31C returns the latched ID in the same cycle. When that ID is nonzero, the read also pulses `claim_vld_o` with `claim_id_o` equal to it. In the next cycle the latched ID is 0 and `irq_o` is low. Arbitration resumes in the cycle after that.
- R8: A write to 0x31C pulses `cmpl_vld_o` in the same cycle, with `cmpl_id_o` equal to bits [ID_W-1:0] of the written value. If the full written value equals the latched ID, the latched ID is 0 in the next cycle.
- R9: Reads of the source-mode words (0x018 to 0x02F), of unmapped addresses and of any address that is not word aligned return 0. Writes to them change nothing.
- R10: After reset, `irq_o` is low, every priority, enable and threshold reads 0, and a claim read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address within the 0x400 region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| src_pend | input | NUM_SRC | Pending level per source; bit i is source i (range NUM_SRC:1) |
| irq_o | output | 1 | Interrupt request to the target |
| claim_vld_o | output | 1 | Claim strobe to the gateway |
| claim_id_o | output | ID_W | ID being claimed |
| cmpl_vld_o | output | 1 | Completion strobe to the gateway |
| cmpl_id_o | output | ID_W | ID being completed |

## Verification
The assertions assume that a read and a write never happen in the same cycle, because there is a single `bus_write` flag. The arbitration assertion assumes that `src_pend` settles before each clock edge, so priority comparisons see stable inputs. The stimulus changes the pending vector and drives every access only on the falling clock edge, and it keeps addresses inside the 10-bit region. Misaligned and unmapped addresses are still sent on purpose so that R9 is exercised.

// File: rtl/plic_tgt_pkg.sv
package plic_tgt_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 3;
  localparam int THR_W  = 2;

  // Word addresses (byte address >> 2); the bus decoder depends on these.
  localparam logic [7:0] PRIO_WORD  = 8'h0C;  // 0x030
  localparam logic [7:0] EN_WORD    = 8'hC0;  // 0x300
  localparam logic [7:0] THR_WORD   = 8'hC6;  // 0x318
  localparam logic [7:0] CLAIM_WORD = 8'hC7;  // 0x31C

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PEND,
    RG_PRIO,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } reg_sel_e;
endpackage

// File: rtl/plic_tgt_decode.sv
module plic_tgt_decode
  import plic_tgt_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int N_WORDS = 2,
  parameter int ID_W    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [ID_W-1:0]   idx
);
  logic [7:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    sel = RG_NONE;
    idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (int'(word) < N_WORDS) begin
        sel = RG_PEND;
        idx = ID_W'(word);
      end else if (word >= PRIO_WORD && int'(word) < int'(PRIO_WORD) + NUM_SRC) begin
        sel = RG_PRIO;
        idx = ID_W'(word - PRIO_WORD + 8'd1);
      end else if (word >= EN_WORD && int'(word) < int'(EN_WORD) + N_WORDS) begin
        sel = RG_EN;
        idx = ID_W'(word - EN_WORD);
      end else if (word == THR_WORD) begin
        sel = RG_THR;
      end else if (word == CLAIM_WORD) begin
        sel = RG_CLAIM;
      end
    end
  end
endmodule

// File: rtl/plic_tgt_regs.sv
module plic_tgt_regs
  import plic_tgt_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int N_WORDS = 2,
  parameter int ID_W    = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  reg_sel_e                        sel,
  input  logic [ID_W-1:0]                 idx,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_SRC:0][PRIO_W-1:0]    prio_o,
  output logic [N_WORDS-1:0][DATA_W-1:0]  en_o,
  output logic [THR_W-1:0]                thr_o
);
  function automatic logic [DATA_W-1:0] word_mask(int w);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) begin
      m[b] = ((DATA_W * w + b) >= 1) && ((DATA_W * w + b) <= NUM_SRC);
    end
    return m;
  endfunction

  assign prio_o[0] = '0;

  generate
    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_prio
      logic              we;
      logic [PRIO_W-1:0] q, d;
      assign we = wr_en && (sel == RG_PRIO) && (idx == ID_W'(k));
      assign d  = we ? wdata[PRIO_W-1:0] : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign prio_o[k] = q;
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_en
      localparam logic [DATA_W-1:0] MASK = word_mask(w);
      logic              we;
      logic [DATA_W-1:0] q, d;
      assign we = wr_en && (sel == RG_EN) && (idx == ID_W'(w));
      assign d  = we ? (wdata & MASK) : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign en_o[w] = q;
    end
  endgenerate

  logic             thr_we;
  logic [THR_W-1:0] thr_q, thr_d;
  assign thr_we = wr_en && (sel == RG_THR);
  assign thr_d  = thr_we ? wdata[THR_W-1:0] : thr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr_d;
  end
  assign thr_o = thr_q;

  // R2
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == RG_THR) |=> $stable(thr_o));
endmodule

// File: rtl/plic_tgt_arb.sv
module plic_tgt_arb
  import plic_tgt_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ID_W    = 6
) (
  input  logic [NUM_SRC:0]             cand,
  input  logic [NUM_SRC:0][PRIO_W-1:0] prio,
  input  logic [THR_W-1:0]             thr,
  output logic [ID_W-1:0]              win_id
);
  logic [PRIO_W-1:0] best_p;

  // Ascending scan with a strict compare: the lowest ID keeps a tie.
  always_comb begin
    best_p = PRIO_W'(thr);
    win_id = '0;
    for (int i = 0; i <= NUM_SRC; i++) begin
      if (cand[i] && (prio[i] > best_p)) begin
        best_p = prio[i];
        win_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/plic_target.sv
module plic_target
  import plic_tgt_pkg::*;
#(
  parameter int NUM_SRC = 40,
  localparam int N_WORDS = (NUM_SRC + DATA_W) / DATA_W,
  localparam int ID_W    = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC:1]   src_pend,
  output logic               irq_o,
  output logic               claim_vld_o,
  output logic [ID_W-1:0]    claim_id_o,
  output logic               cmpl_vld_o,
  output logic [ID_W-1:0]    cmpl_id_o
);
  reg_sel_e                        sel;
  logic [ID_W-1:0]                 idx;
  logic [NUM_SRC:0][PRIO_W-1:0]    prio;
  logic [N_WORDS-1:0][DATA_W-1:0]  en_words;
  logic [N_WORDS-1:0][DATA_W-1:0]  pend_words;
  logic [THR_W-1:0]                thr;
  logic [N_WORDS*DATA_W-1:0]       pend_flat, en_flat;
  logic [NUM_SRC:0]                cand;
  logic [ID_W-1:0]                 arb_id, win_q, win_d;
  logic                            irq_q, irq_d;
  logic                            claim_rd, cmpl_wr, cmpl_hit;

  plic_tgt_decode #(.NUM_SRC(NUM_SRC), .N_WORDS(N_WORDS), .ID_W(ID_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .idx  (idx)
  );

  plic_tgt_regs #(.NUM_SRC(NUM_SRC), .N_WORDS(N_WORDS), .ID_W(ID_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_valid && bus_write),
    .sel    (sel),
    .idx    (idx),
    .wdata  (bus_wdata),
    .prio_o (prio),
    .en_o   (en_words),
    .thr_o  (thr)
  );

  always_comb begin
    pend_flat              = '0;
    pend_flat[NUM_SRC:1]   = src_pend;
  end
  assign pend_words = pend_flat;
  assign en_flat    = en_words;
  assign cand       = pend_flat[NUM_SRC:0] & en_flat[NUM_SRC:0];

  plic_tgt_arb #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .cand   (cand),
    .prio   (prio),
    .thr    (thr),
    .win_id (arb_id)
  );

  assign claim_rd = bus_valid && !bus_write && (sel == RG_CLAIM);
  assign cmpl_wr  = bus_valid &&  bus_write && (sel == RG_CLAIM);
  assign cmpl_hit = cmpl_wr && (bus_wdata == DATA_W'(win_q));

  // Next state of the latched winner.
  always_comb begin
    win_d = (claim_rd || cmpl_hit) ? '0 : arb_id;
    irq_d = (win_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      irq_q <= 1'b0;
    end else begin
      win_q <= win_d;
      irq_q <= irq_d;
    end
  end

  // Read return.
  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (sel)
        RG_PEND: begin
          for (int w = 0; w < N_WORDS; w++)
            if (idx == ID_W'(w)) bus_rdata = pend_words[w];
        end
        RG_PRIO: begin
          for (int k = 0; k <= NUM_SRC; k++)
            if (idx == ID_W'(k)) bus_rdata = DATA_W'(prio[k]);
        end
        RG_EN: begin
          for (int w = 0; w < N_WORDS; w++)
            if (idx == ID_W'(w)) bus_rdata = en_words[w];
        end
        RG_THR:   bus_rdata = DATA_W'(thr);
        RG_CLAIM: bus_rdata = DATA_W'(win_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign irq_o       = irq_q;
  assign claim_vld_o = claim_rd && (win_q != '0);
  assign claim_id_o  = win_q;
  assign cmpl_vld_o  = cmpl_wr;
  assign cmpl_id_o   = bus_wdata[ID_W-1:0];

  // R5
  arb_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_id != '0) |-> (cand[arb_id] && (prio[arb_id] > PRIO_W'(thr))));
  // R6
  irq_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (win_q != '0));
  // R7
  claim_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rd |=> !irq_o);
  // R7
  claim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_vld_o |-> (claim_id_o != '0 && bus_rdata == DATA_W'(claim_id_o)));
  // R8
  cmpl_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld_o && bus_wdata == DATA_W'(win_q)) |=> !irq_o);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({claim_vld_o, cmpl_vld_o}));
endmodule

// File: tb/plic_target_bench.sv
module plic_target_bench;
  localparam int NS  = 40;
  localparam int NW  = 2;
  localparam int IDW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_valid = 1'b0;
  logic            bus_write = 1'b0;
  logic [9:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NS:1]     src_pend = '0;
  logic            irq_o, claim_vld_o, cmpl_vld_o;
  logic [IDW-1:0]  claim_id_o, cmpl_id_o;

  always #2 clk = ~clk;  // 250 MHz

  plic_target #(.NUM_SRC(NS)) u_plic_target (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_pend(src_pend), .irq_o(irq_o), .claim_vld_o(claim_vld_o),
    .claim_id_o(claim_id_o), .cmpl_vld_o(cmpl_vld_o), .cmpl_id_o(cmpl_id_o)
  );

  // Behavioural reference state
  int          n_tests = 0;
  int          n_fail  = 0;
  int          m_prio[NS+1];
  bit          m_en[NS+1];
  int          m_thr = 0;
  int          m_win = 0;
  bit          m_irq = 0;
  logic [NS:1] pend_req = '0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int model_arb();
    int best = 0;
    int bp = m_thr;
    for (int id = 1; id <= NS; id++)
      if (pend_req[id] && m_en[id] && m_prio[id] > bp) begin
        best = id;
        bp = m_prio[id];
      end
    return best;
  endfunction

  function automatic logic [31:0] model_read(logic [9:0] a);
    logic [31:0] r = '0;
    int w;
    if (a[1:0] != 2'b00) return 32'h0;
    if (a < 10'h018) begin
      w = int'(a) / 4;
      if (w < NW)
        for (int b = 0; b < 32; b++) begin
          int id = 32 * w + b;
          if (id >= 1 && id <= NS) r[b] = pend_req[id];
        end
    end else if (a >= 10'h030 && int'(a) < 'h30 + 4 * NS) begin
      r = 32'(m_prio[(int'(a) - 'h30) / 4 + 1]);
    end else if (a >= 10'h300 && int'(a) < 'h300 + 4 * NW) begin
      w = (int'(a) - 'h300) / 4;
      for (int b = 0; b < 32; b++) begin
        int id = 32 * w + b;
        if (id >= 1 && id <= NS) r[b] = m_en[id];
      end
    end else if (a == 10'h318) r = 32'(m_thr);
    else if (a == 10'h31C) r = 32'(m_win);
    return r;
  endfunction

  task automatic model_write(logic [9:0] a, logic [31:0] d);
    int w;
    if (a[1:0] != 2'b00) return;
    if (a >= 10'h030 && int'(a) < 'h30 + 4 * NS)
      m_prio[(int'(a) - 'h30) / 4 + 1] = int'(d & 32'h7);
    else if (a >= 10'h300 && int'(a) < 'h300 + 4 * NW) begin
      w = (int'(a) - 'h300) / 4;
      for (int b = 0; b < 32; b++) begin
        int id = 32 * w + b;
        if (id >= 1 && id <= NS) m_en[id] = d[b];
      end
    end else if (a == 10'h318) m_thr = int'(d & 32'h3);
  endtask

  // One bus cycle, compared against the model on every clock
  task automatic cyc(string tag, bit v, bit wr, logic [9:0] a, logic [31:0] d);
    bit exp_claim, exp_cmpl, clr;
    int nxt;
    @(negedge clk);
    chk(tag, "irq_o", 32'(irq_o), 32'(m_irq));
    src_pend  = pend_req;
    bus_valid = v;
    bus_write = wr;
    bus_addr  = a;
    bus_wdata = d;
    #1;
    if (v && !wr) chk(tag, "rdata", bus_rdata, model_read(a));
    exp_claim = v && !wr && a == 10'h31C && m_win != 0;
    exp_cmpl  = v && wr && a == 10'h31C;
    chk(tag, "claim_vld", 32'(claim_vld_o), 32'(exp_claim));
    if (exp_claim) chk(tag, "claim_id", 32'(claim_id_o), 32'(m_win));
    chk(tag, "cmpl_vld", 32'(cmpl_vld_o), 32'(exp_cmpl));
    if (exp_cmpl) chk(tag, "cmpl_id", 32'(cmpl_id_o), 32'(d[IDW-1:0]));
    @(posedge clk);
    nxt = model_arb();
    clr = (v && a == 10'h31C) && (!wr || d == 32'(m_win));
    if (v && wr) model_write(a, d);
    m_win = clr ? 0 : nxt;
    m_irq = (m_win != 0);
  endtask

  task automatic rd(string tag, logic [9:0] a);
    cyc(tag, 1'b1, 1'b0, a, 32'h0);
  endtask
  task automatic wr(string tag, logic [9:0] a, logic [31:0] d);
    cyc(tag, 1'b1, 1'b1, a, d);
  endtask
  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, 10'h0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i <= NS; i++) begin m_prio[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    // R10: held in reset
    chk("R10", "irq in reset", 32'(irq_o), 32'h0);
    chk("R10", "claim in reset", 32'(claim_vld_o), 32'h0);
    rst_n = 1'b1;
    idle("R10", 2);
    rd("R10", 10'h318);
    rd("R10", 10'h31C);
    rd("R10", 10'h030);
    rd("R10", 10'h300);

    // R1: priority map and masking
    wr("R1", 10'h030, 32'hFFFF_FFFF);
    rd("R1", 10'h030);
    wr("R1", 10'h030 + 10'(4 * (NS - 1)), 32'h0000_000D);
    rd("R1", 10'h030 + 10'(4 * (NS - 1)));
    wr("R1", 10'h038, 32'h2);
    rd("R1", 10'h038);

    // R2: threshold masking and hold
    wr("R2", 10'h318, 32'hFFFF_FFFE);
    rd("R2", 10'h318);
    wr("R2", 10'h318, 32'h1);
    rd("R2", 10'h318);

    // R4: enable storage with hard-wired zeros
    wr("R4", 10'h300, 32'hFFFF_FFFF);
    wr("R4", 10'h304, 32'hFFFF_FFFF);
    rd("R4", 10'h300);
    rd("R4", 10'h304);

    // R3: pending view, writes ignored
    pend_req = '0;
    pend_req[33] = 1'b1;
    pend_req[2]  = 1'b1;
    idle("R3", 1);
    rd("R3", 10'h000);
    rd("R3", 10'h004);
    wr("R3", 10'h000, 32'h0);
    wr("R3", 10'h004, 32'h0);
    rd("R3", 10'h004);
    rd("R3", 10'h000);

    // R9: mode region, unmapped and misaligned
    wr("R9", 10'h018, 32'hFFFF_FFFF);
    wr("R9", 10'h3F0, 32'hFFFF_FFFF);
    wr("R9", 10'h319, 32'hFFFF_FFFF);
    wr("R9", 10'h031, 32'hFFFF_FFFF);
    rd("R9", 10'h018);
    rd("R9", 10'h02C);
    rd("R9", 10'h3F0);
    rd("R9", 10'h301);
    rd("R9", 10'h318);
    rd("R9", 10'h030);

    // R5: ties, strict compare, enable gating
    pend_req = '0;
    idle("R5", 2);
    wr("R5", 10'h030 + 10'(4 * 2), 32'h2);  // source 3
    wr("R5", 10'h030 + 10'(4 * 4), 32'h2);  // source 5
    pend_req[3] = 1'b1;
    pend_req[5] = 1'b1;
    idle("R6", 2);
    rd("R5", 10'h31C);                       // tie: 3 wins
    idle("R5", 2);
    wr("R5", 10'h030 + 10'(4 * 2), 32'h1);  // equals threshold
    idle("R5", 2);
    rd("R5", 10'h31C);                       // now 5
    wr("R5", 10'h318, 32'h2);               // prio 2 not above 2
    idle("R5", 3);
    wr("R5", 10'h318, 32'h1);
    wr("R5", 10'h300, 32'h0);               // disable 1..31
    idle("R5", 3);
    pend_req[40] = 1'b1;                    // source 40 prio 5, enabled
    idle("R6", 1);
    rd("R5", 10'h31C);

    // R7: claim then re-arbitration while still pending
    idle("R7", 2);
    rd("R7", 10'h31C);
    idle("R7", 2);
    pend_req[40] = 1'b0;
    idle("R7", 2);
    rd("R7", 10'h31C);

    // R8: completion, matching and non-matching
    wr("R8", 10'h300, 32'hFFFF_FFFF);
    idle("R8", 2);
    wr("R8", 10'h31C, 32'h0000_0009);       // mismatch: latched stays
    wr("R8", 10'h31C, 32'h0000_0005);       // match: cleared
    idle("R8", 2);
    wr("R8", 10'h31C, 32'h0000_0045);       // id bits 5, full value differs
    idle("R8", 1);
    pend_req = '0;
    idle("R6", 3);
    rd("R10", 10'h31C);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule